// File: doc/BRIEF.md
# Power-Management Register File with Interrupt Controller

This block is the register bank of a power-management companion device. A serial bus front end reaches it through a single-cycle register port: five index bits, sixteen data bits, a request strobe and a write flag. Behind that port sit five pieces of state. The first is an interrupt status/mask pair that drives one interrupt line. The second is a converter window that returns one channel's result with the channel number packed into the same word. The third is a pair of general control registers. The fourth is a calibration word. The fifth is a watchdog index that can ask the system to shut down.

The block never converts anything itself. The converter results arrive on a flat input bus, one field per channel. Three external event inputs report activity on the chip's pins. The power key is a level input. Headset and hook detection are single-cycle pulses. These inputs raise interrupt sources and update a read-only status word. Clock, alarm, audio and similar functions are not built; their indices read as zero.

Top module: `pm_regfile`

## Requirements
- R1: `irq_o` is high exactly when some interrupt status bit is 1 while the same bit of the mask is 0. A mask bit of 1 disables its source. `irq_o` follows the registers with no added delay.
- R2: A write to index 0x01 XORs `wdata_i` into the interrupt status, and a read of 0x01 returns the raw status. Sources that set in the same cycle are ORed in after the XOR. Source bit positions: 0 power key, 1 charger, 2 seconds, 3 minutes, 4 days, 5 alarm, 6 hook, 7 headset, 8 converter sample done.
- R3: After reset the registers hold these values: mask (0x02) = 0xFFFF, interrupt status = 0x0000, calibration (0x06) = 0x0001, device status (0x16) = 0x0020, control 1 (0x0D) = 0, control 2 (0x0E) = 0, channel = 0, sample control (0x09) = `SMP_RESET` (default 0x00C3), `rdata_o` = 0.
- R4: Index 0x00 reads 0x0215, with bit 7 also set while `variant_i` is high. Writes to 0x00 have no effect.
- R5: A read of index 0x08 returns the selected channel in bits 13:10 and that channel's 10-bit result from `adc_results_i[ch*10 +: 10]` in bits 9:0. Bits 15:14 read 0.
- R6: A write to index 0x08 loads the channel from `wdata_i[13:10]` and sets interrupt status bit 8.
- R7: A write to index 0x09 clears every sample control bit that is 1 in `wdata_i` and leaves the other bits unchanged.
- R8: Writing 0x0000 to index 0x17 while control 1 bit 1 is set raises `shutdown_o` for exactly one cycle after the write. Any other value written there, or the same write with that bit clear, gives no pulse. Index 0x17 reads 0.
- R9: Every change of `pwr_key_i` sets interrupt bit 0. Device status bit 5 reads 0 while the key is held (`pwr_key_i` = 1) and 1 while it is released. Both updates take effect one clock after the input changes.
- R10: A pulse on `head_evt_i` sets interrupt bit 7, and a pulse on `hook_evt_i` sets interrupt bit 6, but only when bits 8 and 10 of control 1 are both 1. Otherwise the pulse has no effect.
- R11: Unimplemented indices, and the read-only indices 0x00 and 0x16, ignore writes. Unimplemented indices read 0x0000.
- R12: `rdata_o` is loaded at the clock edge that accepts a read and holds its value until the next read. Indices 0x02, 0x06, 0x0D and 0x0E store and return all 16 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe, one per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 5 | Register index |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |
| variant_i | input | 1 | Device variant strap, shown in the ID word |
| adc_results_i | input | 160 | Converter results, 10 bits per channel, channel 0 in the lowest bits |
| pwr_key_i | input | 1 | Power key level, 1 = pressed |
| head_evt_i | input | 1 | Headset detect event pulse |
| hook_evt_i | input | 1 | Hook detect event pulse |
| irq_o | output | 1 | Interrupt request, active high |
| shutdown_o | output | 1 | One-cycle shutdown request |

## Verification
Write effects (register contents, interrupt status, the channel field) land at the clock edge that accepts the write. Because `irq_o` is combinational from those registers, it is already correct at the falling edge after that write. `rdata_o` and `shutdown_o` are registered at the accepting edge, so they are sampled at the next falling edge. `shutdown_o` is sampled once more one cycle later to confirm the pulse has ended. Changes on the event inputs take one edge to appear, and the bench reads their results back through the register port only after that edge.

// File: rtl/pm_regfile_pkg.sv
`timescale 1ns/1ps
package pm_regfile_pkg;
  localparam int AW = 5;
  localparam int DW = 16;

  localparam logic [AW-1:0] IX_ID    = 5'h00;
  localparam logic [AW-1:0] IX_ISTAT = 5'h01;
  localparam logic [AW-1:0] IX_IMASK = 5'h02;
  localparam logic [AW-1:0] IX_CAL   = 5'h06;
  localparam logic [AW-1:0] IX_CONV  = 5'h08;
  localparam logic [AW-1:0] IX_SMP   = 5'h09;
  localparam logic [AW-1:0] IX_CTL1  = 5'h0D;
  localparam logic [AW-1:0] IX_CTL2  = 5'h0E;
  localparam logic [AW-1:0] IX_DSTAT = 5'h16;
  localparam logic [AW-1:0] IX_WDOG  = 5'h17;

  localparam int SRC_KEY  = 0;
  localparam int SRC_HOOK = 6;
  localparam int SRC_HEAD = 7;
  localparam int SRC_CONV = 8;

  localparam logic [DW-1:0] ID_BASE  = 16'h0215;
  localparam int            ID_VBIT  = 7;
  localparam int            KEY_UP_BIT = 5;
  localparam int            CTL1_WDOG_EN = 1;
  localparam int            CTL1_DET_A = 8;
  localparam int            CTL1_DET_B = 10;

  typedef struct packed {
    logic          req;
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
  } reg_acc_t;
endpackage

// File: rtl/pm_irq_ctrl.sv
`timescale 1ns/1ps
module pm_irq_ctrl #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stat_we_i,
  input  logic          mask_we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] set_i,
  output logic [DW-1:0] stat_o,
  output logic [DW-1:0] mask_o,
  output logic          irq_o
);
  logic [DW-1:0] stat_q, mask_q, toggle;

  assign toggle = stat_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      mask_q <= '1;
    end else begin
      stat_q <= (stat_q ^ toggle) | set_i;
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign stat_o = stat_q;
  assign mask_o = mask_q;
  assign irq_o  = |(stat_q & ~mask_q);
endmodule

// File: rtl/pm_event_gate.sv
`timescale 1ns/1ps
module pm_event_gate
  import pm_regfile_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_key_i,
  input  logic          head_evt_i,
  input  logic          hook_evt_i,
  input  logic [DW-1:0] ctl1_i,
  output logic [DW-1:0] set_o,
  output logic          key_up_o
);
  logic key_q, key_chg, det_en;

  assign key_chg = pwr_key_i ^ key_q;
  assign det_en  = ctl1_i[CTL1_DET_A] & ctl1_i[CTL1_DET_B];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) key_q <= 1'b0;
    else         key_q <= pwr_key_i;
  end

  always_comb begin
    set_o           = '0;
    set_o[SRC_KEY]  = key_chg;
    set_o[SRC_HEAD] = head_evt_i & det_en;
    set_o[SRC_HOOK] = hook_evt_i & det_en;
  end

  assign key_up_o = ~key_q;
endmodule

// File: rtl/pm_conv_port.sv
`timescale 1ns/1ps
module pm_conv_port #(
  parameter int DW    = 16,
  parameter int NCH   = 16,
  parameter int RES_W = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sel_we_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [NCH*RES_W-1:0] results_i,
  output logic [DW-1:0]        word_o
);
  localparam int CH_W = $clog2(NCH);
  localparam int CH_LSB = RES_W;

  logic [CH_W-1:0]  ch_q;
  logic [RES_W-1:0] res_tbl [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign res_tbl[g] = results_i[g*RES_W +: RES_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ch_q <= '0;
    else if (sel_we_i) ch_q <= wdata_i[CH_LSB +: CH_W];
  end

  always_comb begin
    word_o = '0;
    word_o[RES_W-1:0] = res_tbl[ch_q];
    word_o[CH_LSB +: CH_W] = ch_q;
  end
endmodule

// File: rtl/pm_regfile.sv
`timescale 1ns/1ps
module pm_regfile
  import pm_regfile_pkg::*;
#(
  parameter int            NCH       = 16,
  parameter int            RES_W     = 10,
  parameter logic [DW-1:0] SMP_RESET = 16'h00C3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic                 variant_i,
  input  logic [NCH*RES_W-1:0] adc_results_i,
  input  logic                 pwr_key_i,
  input  logic                 head_evt_i,
  input  logic                 hook_evt_i,
  output logic                 irq_o,
  output logic                 shutdown_o
);
  reg_acc_t acc;
  logic wr, rd;
  logic [DW-1:0] stat, mask, ev_set, set_all, conv_word, rd_val;
  logic [DW-1:0] cal_q, ctl1_q, ctl2_q, smp_q, rdata_q;
  logic key_up, conv_wr, sd_q;

  assign acc = '{req: req_i, we: we_i, addr: addr_i, wdata: wdata_i};
  assign wr  = acc.req & acc.we;
  assign rd  = acc.req & ~acc.we;
  assign conv_wr = wr && acc.addr == IX_CONV;

  always_comb begin
    set_all = ev_set;
    set_all[SRC_CONV] = ev_set[SRC_CONV] | conv_wr;
  end

  pm_irq_ctrl #(.DW(DW)) u_irq (
    .clk_i, .rst_ni,
    .stat_we_i (wr && acc.addr == IX_ISTAT),
    .mask_we_i (wr && acc.addr == IX_IMASK),
    .wdata_i   (acc.wdata),
    .set_i     (set_all),
    .stat_o    (stat),
    .mask_o    (mask),
    .irq_o     (irq_o)
  );

  pm_event_gate #(.DW(DW)) u_evt (
    .clk_i, .rst_ni,
    .pwr_key_i, .head_evt_i, .hook_evt_i,
    .ctl1_i   (ctl1_q),
    .set_o    (ev_set),
    .key_up_o (key_up)
  );

  pm_conv_port #(.DW(DW), .NCH(NCH), .RES_W(RES_W)) u_conv (
    .clk_i, .rst_ni,
    .sel_we_i  (conv_wr),
    .wdata_i   (acc.wdata),
    .results_i (adc_results_i),
    .word_o    (conv_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_q  <= 16'h0001;
      ctl1_q <= '0;
      ctl2_q <= '0;
      smp_q  <= SMP_RESET;
      sd_q   <= 1'b0;
    end else begin
      sd_q <= wr && acc.addr == IX_WDOG && acc.wdata == '0 && ctl1_q[CTL1_WDOG_EN];
      if (wr) begin
        unique case (acc.addr)
          IX_CAL:  cal_q  <= acc.wdata;
          IX_CTL1: ctl1_q <= acc.wdata;
          IX_CTL2: ctl2_q <= acc.wdata;
          IX_SMP:  smp_q  <= smp_q & ~acc.wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_val = '0;
    unique case (acc.addr)
      IX_ID: begin
        rd_val = ID_BASE;
        rd_val[ID_VBIT] = variant_i;
      end
      IX_ISTAT: rd_val = stat;
      IX_IMASK: rd_val = mask;
      IX_CAL:   rd_val = cal_q;
      IX_CONV:  rd_val = conv_word;
      IX_SMP:   rd_val = smp_q;
      IX_CTL1:  rd_val = ctl1_q;
      IX_CTL2:  rd_val = ctl2_q;
      IX_DSTAT: rd_val[KEY_UP_BIT] = key_up;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end

  assign rdata_o    = rdata_q;
  assign shutdown_o = sd_q;
endmodule

// File: rtl/pm_regfile_chk.sv
`timescale 1ns/1ps
module pm_regfile_chk
  import pm_regfile_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic          irq_o,
  input logic          shutdown_o
);
  assert_mask_all_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == IX_IMASK && wdata_i == 16'hFFFF) |=> !irq_o);

  assert_id_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == IX_ID) |=> (rdata_o[15:8] == 8'h02 && rdata_o[6:0] == 7'h15));

  assert_sd_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |-> $past(req_i && we_i && addr_i == IX_WDOG && wdata_i == 16'h0000));

  assert_sd_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> !shutdown_o);

  assert_reserved_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == 5'h1F) |=> rdata_o == 16'h0000);

  assert_rdata_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
endmodule

bind pm_regfile pm_regfile_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .shutdown_o(shutdown_o)
);

// File: tb/tb_pm_regfile.sv
`timescale 1ns/1ps
module tb_pm_regfile;
  localparam int NCH = 16;
  localparam int RES_W = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, we_i = 0, variant_i = 0, pwr_key_i = 0, head_evt_i = 0, hook_evt_i = 0;
  logic [4:0] addr_i = '0;
  logic [15:0] wdata_i = '0, rdata_o;
  logic [NCH*RES_W-1:0] adc_results_i;
  logic irq_o, shutdown_o;
  int errors = 0, checks = 0;

  always #2.5 clk_i = ~clk_i;

  pm_regfile dut (.*);

  function automatic logic [9:0] res_of(int c);
    return 10'(c * 37 + 3);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(posedge clk_i); @(negedge clk_i); req_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = a;
    @(posedge clk_i); @(negedge clk_i); req_i = 0; d = rdata_o;
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    check("R3 rdata", rdata_o, 16'h0000);
    check("R3 irq", 16'(irq_o), 16'h0);
    rd_chk("R3 mask", 5'h02, 16'hFFFF);
    rd_chk("R3 istat", 5'h01, 16'h0000);
    rd_chk("R3 cal", 5'h06, 16'h0001);
    rd_chk("R3 dstat", 5'h16, 16'h0020);
    rd_chk("R3 smp", 5'h09, 16'h00C3);
    rd_chk("R3 ctl1", 5'h0D, 16'h0000);
    rd_chk("R3 conv", 5'h08, 16'(res_of(0)));
  endtask

  task automatic t_id;
    rd_chk("R4 id", 5'h00, 16'h0215);
    variant_i = 1;
    rd_chk("R4 id variant", 5'h00, 16'h0295);
    wr(5'h00, 16'h0000);
    rd_chk("R4 id write ignored", 5'h00, 16'h0295);
    variant_i = 0;
  endtask

  task automatic t_conv_irq;
    wr(5'h02, 16'hFEFF);
    check("R1 irq low before", 16'(irq_o), 16'h0);
    wr(5'h08, 16'(5 << 10));
    check("R6 R1 irq after conv write", 16'(irq_o), 16'h1);
    rd_chk("R6 istat bit8", 5'h01, 16'h0100);
    rd_chk("R5 conv ch5", 5'h08, 16'h1400 | 16'(res_of(5)));
    wr(5'h08, 16'hFFFF);
    rd_chk("R5 conv ch15", 5'h08, 16'h3C00 | 16'(res_of(15)));
    wr(5'h01, 16'h0100);
    check("R2 R1 irq cleared by toggle", 16'(irq_o), 16'h0);
    wr(5'h01, 16'h0003);
    rd_chk("R2 toggle sets", 5'h01, 16'h0003);
    check("R1 masked bits quiet", 16'(irq_o), 16'h0);
    wr(5'h02, 16'hFFFD);
    check("R1 unmask bit1", 16'(irq_o), 16'h1);
    wr(5'h01, 16'h0003);
    rd_chk("R2 toggle clears", 5'h01, 16'h0000);
    check("R1 irq after clear", 16'(irq_o), 16'h0);
    wr(5'h02, 16'hFFFF);
  endtask

  task automatic t_sample;
    wr(5'h09, 16'h0041);
    rd_chk("R7 w1c", 5'h09, 16'h0082);
    wr(5'h09, 16'h0000);
    rd_chk("R7 zero write", 5'h09, 16'h0082);
  endtask

  task automatic t_wdog;
    wr(5'h0D, 16'h0000);
    wr(5'h17, 16'h0000);
    check("R8 disabled no pulse", 16'(shutdown_o), 16'h0);
    wr(5'h0D, 16'h0002);
    wr(5'h17, 16'h0001);
    check("R8 nonzero no pulse", 16'(shutdown_o), 16'h0);
    wr(5'h17, 16'h0000);
    check("R8 pulse", 16'(shutdown_o), 16'h1);
    @(negedge clk_i);
    check("R8 pulse ends", 16'(shutdown_o), 16'h0);
    rd_chk("R8 wdog reads 0", 5'h17, 16'h0000);
  endtask

  task automatic t_key;
    @(negedge clk_i); pwr_key_i = 1;
    rd_chk("R9 held status", 5'h16, 16'h0000);
    rd_chk("R9 key irq", 5'h01, 16'h0001);
    wr(5'h01, 16'h0001);
    @(negedge clk_i); pwr_key_i = 0;
    rd_chk("R9 released status", 5'h16, 16'h0020);
    rd_chk("R9 release irq", 5'h01, 16'h0001);
    wr(5'h01, 16'h0001);
  endtask

  task automatic pulse(bit head);
    @(negedge clk_i);
    if (head) head_evt_i = 1; else hook_evt_i = 1;
    @(negedge clk_i); head_evt_i = 0; hook_evt_i = 0;
  endtask

  task automatic t_detect;
    wr(5'h0D, 16'h0100);
    pulse(1); pulse(0);
    rd_chk("R10 gated off", 5'h01, 16'h0000);
    wr(5'h0D, 16'h0500);
    pulse(1);
    rd_chk("R10 head", 5'h01, 16'h0080);
    pulse(0);
    rd_chk("R10 hook", 5'h01, 16'h00C0);
    wr(5'h01, 16'h00C0);
    wr(5'h0D, 16'h0000);
  endtask

  task automatic t_unimpl;
    wr(5'h1F, 16'hFFFF);
    rd_chk("R11 reserved 1F", 5'h1F, 16'h0000);
    wr(5'h03, 16'h1234);
    rd_chk("R11 reserved 03", 5'h03, 16'h0000);
    wr(5'h16, 16'h0000);
    rd_chk("R11 dstat write ignored", 5'h16, 16'h0020);
    rd_chk("R11 mask untouched", 5'h02, 16'hFFFF);
    check("R11 irq quiet", 16'(irq_o), 16'h0);
  endtask

  task automatic t_rw;
    wr(5'h0E, 16'hA5A5);
    rd_chk("R12 ctl2", 5'h0E, 16'hA5A5);
    wr(5'h06, 16'h5A3C);
    rd_chk("R12 cal", 5'h06, 16'h5A3C);
    wr(5'h0D, 16'hFFFF);
    rd_chk("R12 ctl1", 5'h0D, 16'hFFFF);
    wr(5'h0D, 16'h0000);
    check("R12 rdata held across write", rdata_o, 16'hFFFF);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) adc_results_i[c*RES_W +: RES_W] = res_of(c);
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    t_reset();
    t_id();
    t_conv_irq();
    t_sample();
    t_wdog();
    t_key();
    t_detect();
    t_unimpl();
    t_rw();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule